// File: doc/BRIEF.md
# Global clock and control selector

This block sits between the chip's clock pins and two groups of logic cells and I/O cells. Each group receives a clock picked from one of two dedicated clock pins or from a clock term built by the logic array. The picked clock goes unchanged to the group's logic cells, because every logic cell applies its own edge polarity. The same clock also goes through a per-group polarity stage to the group's I/O-cell and input-cell registers. A polarity setting of one makes the falling edge of the source the active edge.

Each group also receives three shared control signals. The group reset and the group preset are each formed as an OR of product terms, and a static mask selects which product terms take part. The fast register-type control lets the group switch its registers between a load type and a count type. When reset and preset are both active, reset wins.

The clock paths are purely combinational and contain no storage. Changing the source select while the clocks run may produce runt pulses. The configuration inputs are meant to be static during operation.

Top module: `gcs_global_sel`

## Requirements
- R1: With a group's source select at 2'b00, that group's logic-cell clock equals clock pin 1.
- R2: With a group's source select at 2'b01, that group's logic-cell clock equals clock pin 2.
- R3: With a group's source select at 2'b10, that group's logic-cell clock equals that group's own logic clock term (bit g of `logic_clk_i`).
- R4: With a group's source select at 2'b11, the logic-cell, I/O-cell and input-cell clocks of that group are all held low, whatever the polarity bits are.
- R5: When the source is not 2'b11, the I/O-cell clock equals the selected clock XOR the group's `ioc_inv_i` bit (1 = inverted).
- R6: When the source is not 2'b11, the input-cell clock equals the selected clock XOR the group's `inc_inv_i` bit, independent of `ioc_inv_i`.
- R7: The logic-cell clock is never affected by either polarity bit.
- R8: A group's reset output is the OR of those of its reset terms whose mask bit is 1. A term whose mask bit is 0 has no effect.
- R9: A group's preset output is the OR of its preset terms whose mask bit is 1. It is forced low while that group's reset output is high.
- R10: A group's register-type output equals its register-type term when its enable bit is 1, and is low when the enable bit is 0.
- R11: Group g uses only bit g of each per-group input and slice g of each multi-bit field (bits [2g+1:2g] of the select, bits [g*TERMS +: TERMS] of the terms and masks). The settings of one group never change the outputs of the other group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_pin1_i | input | 1 | Dedicated clock pin 1 |
| clk_pin2_i | input | 1 | Dedicated clock pin 2 |
| logic_clk_i | input | NUM_GROUPS | Logic-derived clock term, one per group |
| src_sel_i | input | 2*NUM_GROUPS | Clock source select, 2 bits per group |
| ioc_inv_i | input | NUM_GROUPS | I/O-cell clock inversion per group |
| inc_inv_i | input | NUM_GROUPS | Input-cell clock inversion per group |
| rst_terms_i | input | NUM_GROUPS*RST_TERMS | Reset product terms |
| rst_mask_i | input | NUM_GROUPS*RST_TERMS | Reset term participation mask |
| pre_terms_i | input | NUM_GROUPS*PRE_TERMS | Preset product terms |
| pre_mask_i | input | NUM_GROUPS*PRE_TERMS | Preset term participation mask |
| regtype_term_i | input | NUM_GROUPS | Fast register-type term per group |
| regtype_en_i | input | NUM_GROUPS | Register-type control enable per group |
| lcc_clk_o | output | NUM_GROUPS | Logic-cell clock per group |
| ioc_clk_o | output | NUM_GROUPS | I/O-cell clock per group |
| inc_clk_o | output | NUM_GROUPS | Input-cell clock per group |
| grp_rst_o | output | NUM_GROUPS | Group reset |
| grp_pre_o | output | NUM_GROUPS | Group preset |
| grp_regtype_o | output | NUM_GROUPS | Group register-type control |

## Verification
The immediate assertions are evaluated only after each combinational block has settled its outputs. They assume that every select, polarity and mask input holds a known 0 or 1 value, so the source decode always reaches one of its four codes. The stimulus never leaves any input undriven. It changes inputs only half a bench cycle away from the sampling point, so every compared value comes from a settled state.

// File: rtl/gcs_pkg.sv
package gcs_pkg;
  typedef enum logic [1:0] {
    SRC_PIN1  = 2'b00,
    SRC_PIN2  = 2'b01,
    SRC_LOGIC = 2'b10,
    SRC_OFF   = 2'b11
  } clk_src_e;
endpackage

// File: rtl/gcs_clk_lane.sv
module gcs_clk_lane
  import gcs_pkg::*;
(
  input  logic       pin1_i,
  input  logic       pin2_i,
  input  logic       logic_clk_i,
  input  logic [1:0] sel_i,
  input  logic       ioc_inv_i,
  input  logic       inc_inv_i,
  output logic       lcc_clk_o,
  output logic       ioc_clk_o,
  output logic       inc_clk_o
);
  clk_src_e sel;
  logic     src;
  logic     off;

  always_comb begin
    sel = clk_src_e'(sel_i);
    off = 1'b0;
    case (sel)
      SRC_PIN1:  src = pin1_i;
      SRC_PIN2:  src = pin2_i;
      SRC_LOGIC: src = logic_clk_i;
      default: begin
        src = 1'b0;
        off = 1'b1;
      end
    endcase
    lcc_clk_o = src;
    // stopped clock stays low on every branch, polarity not applied
    ioc_clk_o = off ? 1'b0 : (src ^ ioc_inv_i);
    inc_clk_o = off ? 1'b0 : (src ^ inc_inv_i);

    if (sel_i == 2'b11) begin
      assert_off_low_R4: assert (!lcc_clk_o && !ioc_clk_o && !inc_clk_o);
    end else begin
      assert_ioc_pol_R5: assert ((ioc_clk_o ^ lcc_clk_o) == ioc_inv_i);
      assert_inc_pol_R6: assert ((inc_clk_o ^ lcc_clk_o) == inc_inv_i);
    end
  end
endmodule

// File: rtl/gcs_sop_or.sv
module gcs_sop_or #(
  parameter int TERMS = 4
) (
  input  logic [TERMS-1:0] terms_i,
  input  logic [TERMS-1:0] mask_i,
  output logic             hit_o
);
  assign hit_o = |(terms_i & mask_i);
endmodule

// File: rtl/gcs_ctrl_lane.sv
module gcs_ctrl_lane #(
  parameter int RST_TERMS = 4,
  parameter int PRE_TERMS = 4
) (
  input  logic [RST_TERMS-1:0] rst_terms_i,
  input  logic [RST_TERMS-1:0] rst_mask_i,
  input  logic [PRE_TERMS-1:0] pre_terms_i,
  input  logic [PRE_TERMS-1:0] pre_mask_i,
  input  logic                 regtype_term_i,
  input  logic                 regtype_en_i,
  output logic                 rst_o,
  output logic                 pre_o,
  output logic                 regtype_o
);
  logic rst_hit;
  logic pre_hit;

  gcs_sop_or #(.TERMS(RST_TERMS)) u_rst_sop (
    .terms_i (rst_terms_i),
    .mask_i  (rst_mask_i),
    .hit_o   (rst_hit)
  );

  gcs_sop_or #(.TERMS(PRE_TERMS)) u_pre_sop (
    .terms_i (pre_terms_i),
    .mask_i  (pre_mask_i),
    .hit_o   (pre_hit)
  );

  always_comb begin
    rst_o     = rst_hit;
    pre_o     = pre_hit & ~rst_hit;  // reset has priority
    regtype_o = regtype_term_i & regtype_en_i;

    assert_rst_wins_R9: assert (!(rst_o && pre_o));
    if (pre_hit) begin
      assert_pre_or_rst_R9: assert (pre_o != rst_o);
    end
    if (!regtype_en_i) begin
      assert_regtype_gate_R10: assert (!regtype_o);
    end
  end
endmodule

// File: rtl/gcs_global_sel.sv
module gcs_global_sel #(
  parameter int NUM_GROUPS = 2,
  parameter int RST_TERMS  = 4,
  parameter int PRE_TERMS  = 4
) (
  input  logic                            clk_pin1_i,
  input  logic                            clk_pin2_i,
  input  logic [NUM_GROUPS-1:0]           logic_clk_i,
  input  logic [2*NUM_GROUPS-1:0]         src_sel_i,
  input  logic [NUM_GROUPS-1:0]           ioc_inv_i,
  input  logic [NUM_GROUPS-1:0]           inc_inv_i,
  input  logic [NUM_GROUPS*RST_TERMS-1:0] rst_terms_i,
  input  logic [NUM_GROUPS*RST_TERMS-1:0] rst_mask_i,
  input  logic [NUM_GROUPS*PRE_TERMS-1:0] pre_terms_i,
  input  logic [NUM_GROUPS*PRE_TERMS-1:0] pre_mask_i,
  input  logic [NUM_GROUPS-1:0]           regtype_term_i,
  input  logic [NUM_GROUPS-1:0]           regtype_en_i,
  output logic [NUM_GROUPS-1:0]           lcc_clk_o,
  output logic [NUM_GROUPS-1:0]           ioc_clk_o,
  output logic [NUM_GROUPS-1:0]           inc_clk_o,
  output logic [NUM_GROUPS-1:0]           grp_rst_o,
  output logic [NUM_GROUPS-1:0]           grp_pre_o,
  output logic [NUM_GROUPS-1:0]           grp_regtype_o
);
  localparam int SEL_W = 2;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    gcs_clk_lane u_clk (
      .pin1_i      (clk_pin1_i),
      .pin2_i      (clk_pin2_i),
      .logic_clk_i (logic_clk_i[g]),
      .sel_i       (src_sel_i[g*SEL_W +: SEL_W]),
      .ioc_inv_i   (ioc_inv_i[g]),
      .inc_inv_i   (inc_inv_i[g]),
      .lcc_clk_o   (lcc_clk_o[g]),
      .ioc_clk_o   (ioc_clk_o[g]),
      .inc_clk_o   (inc_clk_o[g])
    );

    gcs_ctrl_lane #(
      .RST_TERMS (RST_TERMS),
      .PRE_TERMS (PRE_TERMS)
    ) u_ctrl (
      .rst_terms_i    (rst_terms_i[g*RST_TERMS +: RST_TERMS]),
      .rst_mask_i     (rst_mask_i[g*RST_TERMS +: RST_TERMS]),
      .pre_terms_i    (pre_terms_i[g*PRE_TERMS +: PRE_TERMS]),
      .pre_mask_i     (pre_mask_i[g*PRE_TERMS +: PRE_TERMS]),
      .regtype_term_i (regtype_term_i[g]),
      .regtype_en_i   (regtype_en_i[g]),
      .rst_o          (grp_rst_o[g]),
      .pre_o          (grp_pre_o[g]),
      .regtype_o      (grp_regtype_o[g])
    );
  end
endmodule

// File: tb/gcs_global_sel_bench.sv
module gcs_global_sel_bench;
  localparam int G  = 2;
  localparam int RT = 4;
  localparam int PT = 4;

  typedef struct {
    string        tag;
    logic [G-1:0] lcc, ioc, inc, rst, pre, rtp;
  } item_t;

  logic          clk = 1'b0;
  logic          pin1, pin2;
  logic [G-1:0]  lclk, ioinv, ininv, rtterm, rten;
  logic [2*G-1:0] sel;
  logic [G*RT-1:0] rterms, rmask;
  logic [G*PT-1:0] pterms, pmask;
  logic [G-1:0]  lcc_o, ioc_o, inc_o, rst_o, pre_o, rtp_o;

  item_t q[$];
  int    checks = 0;
  int    errors = 0;
  bit    done   = 1'b0;

  always #10 clk = ~clk;  // 50 MHz pacing clock

  gcs_global_sel #(.NUM_GROUPS(G), .RST_TERMS(RT), .PRE_TERMS(PT)) u_gcs_global_sel (
    .clk_pin1_i     (pin1),
    .clk_pin2_i     (pin2),
    .logic_clk_i    (lclk),
    .src_sel_i      (sel),
    .ioc_inv_i      (ioinv),
    .inc_inv_i      (ininv),
    .rst_terms_i    (rterms),
    .rst_mask_i     (rmask),
    .pre_terms_i    (pterms),
    .pre_mask_i     (pmask),
    .regtype_term_i (rtterm),
    .regtype_en_i   (rten),
    .lcc_clk_o      (lcc_o),
    .ioc_clk_o      (ioc_o),
    .inc_clk_o      (inc_o),
    .grp_rst_o      (rst_o),
    .grp_pre_o      (pre_o),
    .grp_regtype_o  (rtp_o)
  );

  // driver: expected item is built from explicit per-requirement values
  task automatic push(input string tag,
                      input logic [G-1:0] e_lcc, input logic [G-1:0] e_ioc,
                      input logic [G-1:0] e_inc, input logic [G-1:0] e_rst,
                      input logic [G-1:0] e_pre, input logic [G-1:0] e_rtp);
    item_t it;
    it.tag = tag; it.lcc = e_lcc; it.ioc = e_ioc; it.inc = e_inc;
    it.rst = e_rst; it.pre = e_pre; it.rtp = e_rtp;
    q.push_back(it);
    @(posedge clk); #1;
  endtask

  task automatic clear_inputs();
    pin1 = 0; pin2 = 0; lclk = '0; sel = '0; ioinv = '0; ininv = '0;
    rterms = '0; rmask = '0; pterms = '0; pmask = '0; rtterm = '0; rten = '0;
  endtask

  // monitor: sample half a cycle after stimulus
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        checks++;
        if (lcc_o !== it.lcc || ioc_o !== it.ioc || inc_o !== it.inc ||
            rst_o !== it.rst || pre_o !== it.pre || rtp_o !== it.rtp) begin
          errors++;
          $display("FAIL %s: got lcc=%b ioc=%b inc=%b rst=%b pre=%b rt=%b exp lcc=%b ioc=%b inc=%b rst=%b pre=%b rt=%b",
                   it.tag, lcc_o, ioc_o, inc_o, rst_o, pre_o, rtp_o,
                   it.lcc, it.ioc, it.inc, it.rst, it.pre, it.rtp);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    clear_inputs();
    @(posedge clk); #1;
    // idle state, all inputs low: R1 with pin1 low
    push("R1 idle", 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00);
    pin1 = 1; pin2 = 0;
    push("R1 pin1 high", 2'b11, 2'b11, 2'b11, 2'b00, 2'b00, 2'b00);
    sel = 4'b0101; pin1 = 1; pin2 = 0;
    push("R2 pin2 low", 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00);
    pin1 = 0; pin2 = 1;
    push("R2 pin2 high", 2'b11, 2'b11, 2'b11, 2'b00, 2'b00, 2'b00);
    sel = 4'b1010; pin1 = 1; pin2 = 1; lclk = 2'b01;
    push("R3 logic clk", 2'b01, 2'b01, 2'b01, 2'b00, 2'b00, 2'b00);
    lclk = 2'b10;
    push("R3 logic clk B", 2'b10, 2'b10, 2'b10, 2'b00, 2'b00, 2'b00);
    sel = 4'b1111; lclk = 2'b11; ioinv = 2'b11; ininv = 2'b11;
    push("R4 off", 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00);
    clear_inputs(); ioinv = 2'b01;
    push("R5 R7 ioc inv A", 2'b00, 2'b01, 2'b00, 2'b00, 2'b00, 2'b00);
    pin1 = 1;
    push("R5 R7 ioc inv high", 2'b11, 2'b10, 2'b11, 2'b00, 2'b00, 2'b00);
    ioinv = 2'b00; ininv = 2'b10; pin1 = 0;
    push("R6 R7 inc inv B", 2'b00, 2'b00, 2'b10, 2'b00, 2'b00, 2'b00);
    clear_inputs(); rterms = 8'b0110_1001; rmask = 8'b1001_0110;
    push("R8 masked off", 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00);
    rmask = 8'b0000_1000;
    push("R8 group A term3", 2'b00, 2'b00, 2'b00, 2'b01, 2'b00, 2'b00);
    rmask = 8'b0100_0000;
    push("R8 group B term2", 2'b00, 2'b00, 2'b00, 2'b10, 2'b00, 2'b00);
    rterms = '0; rmask = '0; pterms = 8'b0001_0001; pmask = 8'b0001_0001;
    push("R9 preset both", 2'b00, 2'b00, 2'b00, 2'b00, 2'b11, 2'b00);
    rterms = 8'b0000_0010; rmask = 8'b0000_0010;
    push("R9 reset wins A", 2'b00, 2'b00, 2'b00, 2'b01, 2'b10, 2'b00);
    pmask = 8'b0000_0000;
    push("R9 preset masked", 2'b00, 2'b00, 2'b00, 2'b01, 2'b00, 2'b00);
    clear_inputs(); rtterm = 2'b11; rten = 2'b00;
    push("R10 disabled", 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00);
    rten = 2'b10;
    push("R10 enabled B", 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b10);
    rtterm = 2'b01; rten = 2'b11;
    push("R10 term A", 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b01);
    // R11: A on pin2 inverted io, B on logic with reset
    clear_inputs(); sel = 4'b1001; pin2 = 1; lclk = 2'b00; ioinv = 2'b01;
    rterms = 8'b1111_0000; rmask = 8'b1111_0000; pterms = 8'b1111_1111; pmask = 8'b1111_1111;
    push("R11 independent", 2'b01, 2'b00, 2'b01, 2'b10, 2'b01, 2'b00);
    sel = 4'b1100;
    push("R11 B off A pin1", 2'b00, 2'b01, 2'b00, 2'b10, 2'b01, 2'b00);
    while (q.size() > 0) @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule